// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Host Controller

This block is a clocked sequencer on the host side of a byte-wide parallel EEPROM. It drives the device address, the data bus, and active-low chip enable, output enable and write enable. A request carries a start address, a byte count and a read/write flag. For a write, the data bytes arrive on their own valid/ready stream. For a read, one byte comes back on a result strobe.

A write is issued as a series of byte-load strobes gated by write enable. All strobes in one series stay inside a single page. After the last byte of each series, the controller deselects the device and waits out the internal programming time before it touches the bus again. A request that runs past the end of a page is split into one series per page.

The device starts programming on its own if the next strobe is late. When the next byte does not arrive in time, the controller closes the series itself. It waits out the programming time and then carries on with the remaining bytes as a fresh series. All bus timings are clock-cycle-count parameters. After reset, a fixed power-up delay blocks reads for a short time and writes for a longer time.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset release, `req_ready_o` stays low for a read request until T_PU_RD clock cycles have passed, and for a write request until T_PU_WR cycles have passed. Chip enable stays high before T_PU_RD cycles, and no write strobe starts before T_PU_WR cycles.
- R2: During reset, chip enable, output enable and write enable are high (1), the data bus driver is off (`mem_dq_oe_o`=0) and `rdata_valid_o` is 0.
- R3: Write enable is low only while chip enable is low and output enable is high. Each low pulse lasts exactly T_WP cycles. Address and data are driven for exactly T_SETUP cycles before the falling edge and for exactly T_HOLD cycles after the rising edge.
- R4: A write request with length field L stores L+1 bytes, taken in stream order, at consecutive addresses starting at `req_addr_i`.
- R5: All strobes inside one chip-enable-low series have the same address bits above bit PAGE_W-1. A request touching k pages produces exactly k series, each ended by chip enable going high.
- R6: Within one series, the distance from one write-enable falling edge to the next is less than T_BLC_MAX cycles.
- R7: If the next byte of a series is not offered in time to meet R6, the controller ends the series after the bytes already loaded. It waits the programming time and then writes the remaining bytes, at the following addresses, as a new series.
- R8: After each series, chip enable stays high for at least T_WC cycles before it goes low again.
- R9: A read holds chip enable and output enable low with write enable high for T_RD cycles. It then pulses `rdata_valid_o` for one cycle with the byte at `req_addr_i`. The length field is ignored: exactly one byte is returned.
- R10: The data bus driver is on only during the setup, strobe and hold windows of a byte load. It is never on while output enable is low.
- R11: `wdata_ready_o` is high only while a write request is waiting for its next byte. It is low whenever the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Start address |
| req_len_i | input | LEN_W | Byte count minus one (writes only) |
| wdata_valid_i | input | 1 | Write byte valid |
| wdata_ready_o | output | 1 | Write byte taken when high with valid |
| wdata_i | input | DATA_W | Write byte |
| rdata_valid_o | output | 1 | One-cycle read result strobe |
| rdata_o | output | DATA_W | Read byte |
| mem_addr_o | output | ADDR_W | Device address |
| mem_dq_o | output | DATA_W | Data driven to the device |
| mem_dq_oe_o | output | 1 | Data bus driver enable |
| mem_dq_i | input | DATA_W | Data returned by the device |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |

## Verification
The bench builds the controller with a 6-bit address, 4-byte pages (PAGE_W=2), a 3-bit length field and short cycle-count timings: T_BLC_MAX=16, T_WC=20 and power-up delays of 10 and 40 cycles. With these values, every start offset within a page meets every burst length from 1 to 8 bytes. That covers bursts that fill, cross and span several pages. It also brings the byte-load timeout and the programming wait within a few dozen cycles, and the whole 64-byte array can be read back and compared against values computed in the bench.

// File: rtl/epw_pkg.sv
package epw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_PROG,
    ST_READ
  } epw_state_e;

  // bus control bundle, all active low except drive enable
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } epw_bus_t;
endpackage

// File: rtl/epw_powerup.sv
module epw_powerup #(
  parameter int T_PU_RD = 5000,
  parameter int T_PU_WR = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rd_ok_o,
  output logic wr_ok_o
);
  localparam int PU_MAX = (T_PU_WR > T_PU_RD) ? T_PU_WR : T_PU_RD;
  localparam int PW     = $clog2(PU_MAX + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (cnt_q != PW'(PU_MAX))     cnt_q <= cnt_q + 1'b1;
  end

  assign rd_ok_o = (cnt_q >= PW'(T_PU_RD));
  assign wr_ok_o = (cnt_q >= PW'(T_PU_WR));
endmodule

// File: rtl/epw_addr_track.sv
module epw_addr_track #(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              page_end_o,
  output logic              done_o
);
  localparam int RW = LEN_W + 1;

  logic [ADDR_W-1:0] addr_q;
  logic [RW-1:0]     rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      rem_q  <= RW'(len_i) + RW'(1);
    end else if (step_i) begin
      addr_q <= addr_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign addr_o     = addr_q;
  assign last_o     = (rem_q == RW'(1));
  assign done_o     = (rem_q == '0);
  // current byte occupies the top slot of its page
  assign page_end_o = &addr_q[PAGE_W-1:0];
endmodule

// File: rtl/epw_seq.sv
module epw_seq
  import epw_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int T_SETUP   = 2,
  parameter int T_WP      = 12,
  parameter int T_HOLD    = 2,
  parameter int T_BLC_MAX = 4000,
  parameter int T_WC      = 500000,
  parameter int T_RD      = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              rd_ok_i,
  input  logic              wr_ok_i,
  output logic              req_ready_o,
  output logic              load_o,
  input  logic              wdata_valid_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wdata_ready_o,
  input  logic              last_i,
  input  logic              page_end_i,
  input  logic              done_i,
  output logic              step_o,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o
);
  // cycles allowed in the gap state so that fall-to-fall stays below T_BLC_MAX
  localparam int G_MAX = T_BLC_MAX - 1 - T_WP - T_HOLD - T_SETUP;
  localparam int M1    = (T_WC > T_RD) ? T_WC : T_RD;
  localparam int M2    = (T_WP > T_SETUP) ? T_WP : T_SETUP;
  localparam int M3    = (G_MAX > T_HOLD) ? G_MAX : T_HOLD;
  localparam int M12   = (M1 > M2) ? M1 : M2;
  localparam int TMAX  = (M12 > M3) ? M12 : M3;
  localparam int CW    = $clog2(TMAX + 1);

  epw_state_e        state_q, state_d;
  logic              first_q, first_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] dq_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rv_q;
  epw_bus_t          bus_q, bus_d;
  logic              cnt_zero, accept, timeout;

  function automatic epw_bus_t decode(epw_state_e s, logic f);
    epw_bus_t b;
    b = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    unique case (s)
      ST_SETUP:  begin b.ce_n = 1'b0; b.dq_oe = 1'b1; end
      ST_STROBE: begin b.ce_n = 1'b0; b.dq_oe = 1'b1; b.we_n = 1'b0; end
      ST_HOLD:   begin b.ce_n = 1'b0; b.dq_oe = 1'b1; end
      ST_GAP:    b.ce_n = f;
      ST_READ:   begin b.ce_n = 1'b0; b.oe_n = 1'b0; end
      default:   ;
    endcase
    return b;
  endfunction

  assign cnt_zero      = (cnt_q == '0);
  assign req_ready_o   = (state_q == ST_IDLE) && (req_write_i ? wr_ok_i : rd_ok_i);
  assign load_o        = req_valid_i && req_ready_o;
  assign wdata_ready_o = (state_q == ST_GAP);
  assign accept        = wdata_valid_i && wdata_ready_o;
  assign timeout       = (state_q == ST_GAP) && !first_q && !wdata_valid_i &&
                         (cnt_q == CW'(G_MAX - 1));
  assign step_o        = (state_q == ST_HOLD) && cnt_zero;

  always_comb begin
    state_d = state_q;
    first_d = first_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load_o) begin
          if (req_write_i) begin
            state_d = ST_GAP;
            first_d = 1'b1;
            cnt_d   = '0;
          end else begin
            state_d = ST_READ;
            cnt_d   = CW'(T_RD - 1);
          end
        end
      end
      ST_GAP: begin
        if (accept) begin
          state_d = ST_SETUP;
          cnt_d   = CW'(T_SETUP - 1);
        end else if (timeout) begin
          state_d = ST_PROG;
          cnt_d   = CW'(T_WC - 1);
        end else if (!first_q) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          state_d = ST_STROBE;
          cnt_d   = CW'(T_WP - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_STROBE: begin
        if (cnt_zero) begin
          state_d = ST_HOLD;
          cnt_d   = CW'(T_HOLD - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_HOLD: begin
        if (cnt_zero) begin
          if (last_i || page_end_i) begin
            state_d = ST_PROG;
            cnt_d   = CW'(T_WC - 1);
          end else begin
            state_d = ST_GAP;
            first_d = 1'b0;
            cnt_d   = '0;
          end
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_PROG: begin
        if (cnt_zero) begin
          if (done_i) state_d = ST_IDLE;
          else begin
            state_d = ST_GAP;
            first_d = 1'b1;
            cnt_d   = '0;
          end
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_READ: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign bus_d = decode(state_d, first_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      first_q <= 1'b1;
      cnt_q   <= '0;
      bus_q   <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
      dq_q    <= '0;
      rdata_q <= '0;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
      cnt_q   <= cnt_d;
      bus_q   <= bus_d;
      if (accept) dq_q <= wdata_i;
      rv_q <= (state_q == ST_READ) && cnt_zero;
      if ((state_q == ST_READ) && cnt_zero) rdata_q <= dq_i;
    end
  end

  assign ce_n_o        = bus_q.ce_n;
  assign oe_n_o        = bus_q.oe_n;
  assign we_n_o        = bus_q.we_n;
  assign dq_oe_o       = bus_q.dq_oe;
  assign dq_o          = dq_q;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rv_q;
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 8,
  parameter int LEN_W     = 9,
  parameter int T_SETUP   = 2,
  parameter int T_WP      = 12,
  parameter int T_HOLD    = 2,
  parameter int T_BLC_MAX = 4000,
  parameter int T_WC      = 500000,
  parameter int T_RD      = 14,
  parameter int T_PU_RD   = 5000,
  parameter int T_PU_WR   = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              wdata_valid_i,
  output logic              wdata_ready_o,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rdata_valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o
);
  logic rd_ok, wr_ok, load, step, last, page_end, done;

  epw_powerup #(
    .T_PU_RD(T_PU_RD),
    .T_PU_WR(T_PU_WR)
  ) pu_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_ok_o(rd_ok),
    .wr_ok_o(wr_ok)
  );

  epw_addr_track #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W),
    .LEN_W (LEN_W)
  ) at_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .addr_i    (req_addr_i),
    .len_i     (req_len_i),
    .step_i    (step),
    .addr_o    (mem_addr_o),
    .last_o    (last),
    .page_end_o(page_end),
    .done_o    (done)
  );

  epw_seq #(
    .DATA_W   (DATA_W),
    .T_SETUP  (T_SETUP),
    .T_WP     (T_WP),
    .T_HOLD   (T_HOLD),
    .T_BLC_MAX(T_BLC_MAX),
    .T_WC     (T_WC),
    .T_RD     (T_RD)
  ) seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .rd_ok_i      (rd_ok),
    .wr_ok_i      (wr_ok),
    .req_ready_o  (req_ready_o),
    .load_o       (load),
    .wdata_valid_i(wdata_valid_i),
    .wdata_i      (wdata_i),
    .wdata_ready_o(wdata_ready_o),
    .last_i       (last),
    .page_end_i   (page_end),
    .done_i       (done),
    .step_o       (step),
    .dq_i         (mem_dq_i),
    .dq_o         (mem_dq_o),
    .dq_oe_o      (mem_dq_oe_o),
    .ce_n_o       (mem_ce_n_o),
    .oe_n_o       (mem_oe_n_o),
    .we_n_o       (mem_we_n_o),
    .rdata_o      (rdata_o),
    .rdata_valid_o(rdata_valid_o)
  );
endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_W    = 8,
  parameter int T_WP      = 12,
  parameter int T_BLC_MAX = 4000,
  parameter int T_WC      = 500000,
  parameter int T_PU_RD   = 5000,
  parameter int T_PU_WR   = 250000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              mem_dq_oe_o,
  input logic              rdata_valid_o,
  input logic              wdata_ready_o,
  input logic              req_ready_o
);
  int unsigned wl_q, sf_q, ch_q, pu_q;
  logic        we_q, ce_q, oe_q, grp_q, wrote_q;
  logic [ADDR_W-PAGE_W-1:0] pg_q;
  logic        fall, ce_fall;

  assign fall    = !mem_we_n_o && we_q;
  assign ce_fall = !mem_ce_n_o && ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wl_q <= 0; sf_q <= 0; ch_q <= 0; pu_q <= 0;
      we_q <= 1'b1; ce_q <= 1'b1; oe_q <= 1'b1;
      grp_q <= 1'b0; wrote_q <= 1'b0; pg_q <= '0;
    end else begin
      we_q <= mem_we_n_o;
      ce_q <= mem_ce_n_o;
      oe_q <= mem_oe_n_o;
      wl_q <= mem_we_n_o ? 0 : wl_q + 1;
      if (pu_q <= T_PU_WR) pu_q <= pu_q + 1;
      if (fall) sf_q <= 1;
      else if (sf_q < T_BLC_MAX) sf_q <= sf_q + 1;
      if (mem_ce_n_o) ch_q <= (ch_q < T_WC) ? ch_q + 1 : ch_q;
      else            ch_q <= 0;
      if (mem_ce_n_o) grp_q <= 1'b0;
      else if (fall)  grp_q <= 1'b1;
      if (fall && !grp_q) pg_q <= mem_addr_o[ADDR_W-1:PAGE_W];
      if (fall)         wrote_q <= 1'b1;
      else if (ce_fall) wrote_q <= 1'b0;
    end
  end

  a_r3_we_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_ce_n_o && mem_oe_n_o));

  a_r3_we_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_n_o && !we_q) |-> (wl_q == T_WP));

  a_r10_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_oe_n_o && !mem_ce_n_o));

  a_r6_load_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && grp_q) |-> (sf_q < T_BLC_MAX));

  a_r5_same_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && grp_q) |-> (mem_addr_o[ADDR_W-1:PAGE_W] == pg_q));

  a_r8_prog_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_fall && wrote_q) |-> (ch_q >= T_WC));

  a_r1_no_early_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_q < T_PU_RD) |-> mem_ce_n_o);

  a_r1_no_early_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |-> (pu_q >= T_PU_WR));

  a_r9_read_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> !oe_q);

  a_r11_ready_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_ready_o |-> !req_ready_o);
endmodule

bind eeprom_page_ctrl epw_checker #(
  .ADDR_W   (ADDR_W),
  .PAGE_W   (PAGE_W),
  .T_WP     (T_WP),
  .T_BLC_MAX(T_BLC_MAX),
  .T_WC     (T_WC),
  .T_PU_RD  (T_PU_RD),
  .T_PU_WR  (T_PU_WR)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_addr_o   (mem_addr_o),
  .mem_ce_n_o   (mem_ce_n_o),
  .mem_oe_n_o   (mem_oe_n_o),
  .mem_we_n_o   (mem_we_n_o),
  .mem_dq_oe_o  (mem_dq_oe_o),
  .rdata_valid_o(rdata_valid_o),
  .wdata_ready_o(wdata_ready_o),
  .req_ready_o  (req_ready_o)
);

// File: tb/eeprom_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_ctrl_tb_top;
  localparam int AW = 6, DW = 8, PW = 2, LW = 3;
  localparam int TS = 2, TWP = 3, TH = 1, TBLC = 16, TWC = 20, TRD = 3;
  localparam int TPR = 10, TPW = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, wvalid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [DW-1:0] wdata = '0;
  logic req_ready_o, wdata_ready_o, rdata_valid_o;
  logic [DW-1:0] rdata_o, mem_dq_o;
  logic [DW-1:0] mem_dq_i;
  logic [AW-1:0] mem_addr_o;
  logic mem_dq_oe_o, mem_ce_n_o, mem_oe_n_o, mem_we_n_o;

  eeprom_page_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .LEN_W(LW),
    .T_SETUP(TS), .T_WP(TWP), .T_HOLD(TH), .T_BLC_MAX(TBLC),
    .T_WC(TWC), .T_RD(TRD), .T_PU_RD(TPR), .T_PU_WR(TPW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .wdata_valid_i(wvalid), .wdata_ready_o(wdata_ready_o), .wdata_i(wdata),
    .rdata_valid_o(rdata_valid_o), .rdata_o(rdata_o),
    .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i(mem_dq_i), .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o),
    .mem_we_n_o(mem_we_n_o)
  );

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] exp_m [DEPTH];
  int errs = 0, chks = 0, cyc = 0, groups = 0, rv_cnt = 0;
  bit finished = 0;

  always_comb mem_dq_i = (!mem_ce_n_o && !mem_oe_n_o) ? mem[mem_addr_o] : 8'h00;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // device-side model and bus monitor
  logic we_p = 1, ce_p = 1, dqoe_p = 0;
  int wlow = 0, drv = 0, lastf = 0, chigh = 0, grp_page = 0;
  bit in_grp = 0, pend_prog = 0;
  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n_o && (mem_ce_n_o || !mem_oe_n_o)) check(0, "R3 strobe gating", 1, 0);
    if (mem_dq_oe_o && !mem_oe_n_o) check(0, "R10 bus contention", 1, 0);
    if (!mem_ce_n_o && cyc < TPR) check(0, "R1 early chip enable", cyc, TPR);
    if (!mem_we_n_o) wlow++;
    if (mem_we_n_o && !we_p) begin
      check(wlow == TWP, "R3 strobe width", wlow, TWP);
      wlow = 0;
      mem[mem_addr_o] = mem_dq_o;
      drv = 1;
    end else if (mem_dq_oe_o && mem_we_n_o) drv++;
    if (!mem_dq_oe_o && dqoe_p) begin
      check(drv == TH, "R3 hold window", drv, TH);
      drv = 0;
    end
    if (!mem_we_n_o && we_p) begin
      check(drv == TS, "R3 setup window", drv, TS);
      drv = 0;
      if (cyc < TPW) check(0, "R1 early write", cyc, TPW);
      if (in_grp) begin
        check(cyc - lastf < TBLC, "R6 load gap", cyc - lastf, TBLC - 1);
        check(int'(mem_addr_o >> PW) == grp_page, "R5 page kept", mem_addr_o >> PW, grp_page);
      end else grp_page = int'(mem_addr_o >> PW);
      in_grp = 1;
      lastf = cyc;
    end
    if (mem_ce_n_o && !ce_p) begin
      chigh = 1;
      if (in_grp) begin groups++; pend_prog = 1; in_grp = 0; end
    end else if (mem_ce_n_o) chigh++;
    if (!mem_ce_n_o && ce_p && pend_prog) begin
      check(chigh >= TWC, "R8 program wait", chigh, TWC);
      pend_prog = 0;
    end
    if (rdata_valid_o) rv_cnt++;
    we_p = mem_we_n_o; ce_p = mem_ce_n_o; dqoe_p = mem_dq_oe_o;
  end

  task automatic issue(input bit w, input int a, input int l);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = AW'(a); req_len = LW'(l);
    #1;
    while (!req_ready_o) begin @(negedge clk); #1; end
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic wr_req(input int a, input int n, input int slow_i, input int slow_d, input int exp_g);
    int g0;
    logic [DW-1:0] v;
    g0 = groups;
    issue(1, a, n - 1);
    for (int i = 0; i < n; i++) begin
      v = DW'(a * 3 + i * 17 + n * 29 + 5);
      if (i == slow_i) repeat (slow_d) @(negedge clk);
      @(negedge clk);
      wvalid = 1; wdata = v;
      #1;
      while (!wdata_ready_o) begin @(negedge clk); #1; end
      @(posedge clk); #1 wvalid = 0;
      exp_m[a + i] = v;
    end
    @(negedge clk); #1;
    while (!req_ready_o) begin @(negedge clk); #1; end
    check(groups - g0 == exp_g, (slow_d > 0) ? "R7 series count" : "R5 series count",
          groups - g0, exp_g);
    check(!wdata_ready_o, "R11 idle ready", wdata_ready_o, 0);
  endtask

  task automatic rd_req(input int a, input int l);
    int r0;
    r0 = rv_cnt;
    req_write = 0;
    issue(0, a, l);
    @(negedge clk);
    while (!rdata_valid_o) @(negedge clk);
    check(rdata_o == exp_m[a], "R4/R9 read data", rdata_o, exp_m[a]);
    repeat (4) @(negedge clk);
    if (l != 0) check(rv_cnt - r0 == 1, "R9 single byte", rv_cnt - r0, 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'hFF; exp_m[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    check({mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o, rdata_valid_o} == 5'b11100,
          "R2 reset outputs", {mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o, rdata_valid_o}, 5'b11100);
    rst_n = 1;
    req_write = 1;
    while (cyc < TPR - 1) @(negedge clk);
    req_write = 0; #1;
    check(!req_ready_o, "R1 read held", req_ready_o, 0);
    @(negedge clk); #1;
    check(req_ready_o, "R1 read allowed", req_ready_o, 1);
    req_write = 1; #1;
    check(!req_ready_o, "R1 write held", req_ready_o, 0);
    check(!wdata_ready_o, "R11 no data ready at rest", wdata_ready_o, 0);
    while (cyc < TPW - 1) @(negedge clk);
    #1 check(!req_ready_o, "R1 write held to limit", req_ready_o, 0);
    @(negedge clk); #1;
    check(req_ready_o, "R1 write allowed", req_ready_o, 1);

    // sweep start offsets and burst lengths
    for (int a = 0; a < 16; a++)
      for (int n = 1; n <= 8; n++)
        wr_req(a + (n % 4) * 8, n, -1, 0, (((a + (n % 4) * 8) + n - 1) >> PW) - ((a + (n % 4) * 8) >> PW) + 1);

    // late byte inside one page: series split by timeout
    wr_req(48, 3, 1, 30, 2);
    wr_req(52, 4, 2, 40, 2);
    // slightly late byte that still fits the window
    wr_req(56, 3, 1, 2, 1);

    for (int a = 0; a < DEPTH; a++) rd_req(a, 0);
    rd_req(5, 6);
    rd_req(50, 7);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  always @(posedge clk) if (cyc > 150000 && !finished) begin
    finished = 1;
    errs++; chks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule